// File: doc/BRIEF.md
# Standby Mode Power Controller

This block sequences the low-power modes of a small microcontroller. The CPU writes a standby control byte; one bit asks for a light sleep, in which only the CPU clock stops and the peripherals keep running. A second bit asks for a deep watch mode. In watch mode both the CPU and peripheral clock enables drop, leaving only the always-on timekeeping and wake-up logic alive, and the pins are either frozen or floated. A third bit of the same byte chooses between freezing and floating the pins.

A mode is left on an interrupt or on an external reset. Any pending interrupt ends sleep. Only an interrupt whose priority level exceeds 11 ends watch. An interrupt-driven exit raises a one-cycle wake pulse, so the CPU can either take the interrupt or resume at the next instruction. When an external reset ends watch mode and the power-on-reset strap is set, the CPU is held in reset through an oscillator stabilization wait of selectable length before it is released. The oscillator, interrupt controller and CPU are outside the block; their relevant signals arrive as inputs.

The controller has four states. RUN is normal execution. SLEEP has the CPU clock gated. WATCH has all gated clocks off. STAB is the stabilization wait with the CPU held in reset. The transitions are:
- RUN→SLEEP on an accepted sleep write.
- RUN→WATCH on an accepted watch write.
- SLEEP→RUN on any interrupt or on an external reset.
- WATCH→RUN on an interrupt above level 11, or on an external reset when the strap is clear.
- WATCH→STAB on an external reset when the strap is set.
- STAB→RUN when the wait count expires.

Top module: `stby_ctrl`

## Requirements
- R1: After power-on reset the block is in RUN with cpu_clk_en=1, periph_clk_en=1, pin_hold=0, pin_hiz=0, cpu_rst=0 and wake_pulse=0.
- R2: In RUN, a write with bit 6 set (and no pending interrupt) enters SLEEP from the next cycle. SLEEP has cpu_clk_en=0 and periph_clk_en=1.
- R3: In RUN, a write with bit 3 set and bit 6 clear enters WATCH, which has cpu_clk_en=0 and periph_clk_en=0. The write is ignored while clk_sel_sub=1.
- R4: A sleep or watch write made while irq_pend=1 has no effect, and the block stays in RUN with its clocks running.
- R5: In WATCH, bit 5 of the entering write selects the pin behaviour. A value of 0 gives pin_hold=1 and pin_hiz=0. A value of 1 gives pin_hiz=1 and pin_hold=0. Outside WATCH both pin outputs are 0.
- R6: In WATCH, a pending interrupt with irq_level greater than 11 returns the block to RUN. A level of 11 or below leaves WATCH unchanged.
- R7: In SLEEP, any pending interrupt returns the block to RUN, whatever its level.
- R8: Each interrupt-driven return to RUN raises wake_pulse for exactly the first RUN cycle. An exit caused by reset raises no wake pulse.
- R9: With por_strap=1, an ext_rst in WATCH moves the block to STAB. STAB lasts 2^(STAB_BASE_LOG2+2*wait_sel) cycles, during which cpu_rst=1 and both clock enables are 0. The block then enters RUN.
- R10: With por_strap=0, an ext_rst in WATCH returns the block directly to RUN without any wait. An ext_rst in SLEEP always returns the block directly to RUN. cpu_rst follows ext_rst.
- R11: A RUN write with both bit 6 and bit 3 set enters SLEEP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| por_n | input | 1 | Asynchronous active-low power-on reset of the block |
| ext_rst | input | 1 | External reset request, active high |
| reg_wr | input | 1 | Write strobe for the standby control byte |
| reg_wdata | input | 8 | Write data: bit 6 sleep, bit 5 pin float, bit 3 watch |
| clk_sel_sub | input | 1 | System clock currently taken from the subclock |
| irq_pend | input | 1 | Some interrupt request is pending |
| irq_level | input | 4 | Priority level of the pending interrupt |
| por_strap | input | 1 | Power-on-reset configuration strap |
| wait_sel | input | 2 | Stabilization wait length selector |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pin_hold | output | 1 | Freeze pins at their last state |
| pin_hiz | output | 1 | Put pins in high impedance |
| cpu_rst | output | 1 | Reset held on the CPU |
| wake_pulse | output | 1 | One-cycle pulse on an interrupt-driven exit |

## Verification
The hardest situation to reach is the end of the stabilization wait. Getting there needs an accepted watch entry, then a reset with the strap set, then a count that runs thousands of cycles at default sizes. The bench shrinks the base exponent through its parameter and drives this path in a directed sequence, with the shortest and the longest selector value. Refused entries are sparse under random stimulus because they need a write together with a pending interrupt or the subclock flag. The random phase therefore raises those inputs with a fixed bias and tracks the mode in a bench model.

// File: rtl/stby_pkg.sv
package stby_pkg;
    localparam int SLP_BIT = 6;
    localparam int FLT_BIT = 5;
    localparam int WCH_BIT = 3;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WATCH = 2'd2,
        ST_STAB  = 2'd3
    } stby_state_t;
endpackage

// File: rtl/stby_req_decode.sv
module stby_req_decode #(
    parameter int DATA_W = 8
) (
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_pend,
    input  logic              clk_sel_sub,
    output logic              go_sleep,
    output logic              go_watch,
    output logic              float_sel
);
    import stby_pkg::*;

    logic accept;

    always_comb begin
        accept    = wr && !irq_pend;
        go_sleep  = accept && wdata[SLP_BIT];
        go_watch  = accept && wdata[WCH_BIT] && !wdata[SLP_BIT] && !clk_sel_sub;
        float_sel = wdata[FLT_BIT];
    end
endmodule

// File: rtl/stby_stab_timer.sv
module stby_stab_timer #(
    parameter int BASE_LOG2 = 12,
    parameter int STEP_LOG2 = 2,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    localparam int CW = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1);

    logic [CW-1:0]    cnt;
    logic [SEL_W-1:0] sel_q;
    logic [CW:0]      span;
    logic [CW-1:0]    last;

    always_comb begin
        span = (CW+1)'(1) << (BASE_LOG2 + STEP_LOG2 * int'(sel_q));
        last = CW'(span - 1'b1);
        done = run && (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            sel_q <= '0;
        end else if (!run) begin
            cnt   <= '0;
            sel_q <= sel;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run && !done |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl #(
    parameter int DATA_W         = 8,
    parameter int LVL_W          = 4,
    parameter int WAKE_LVL       = 11,
    parameter int STAB_BASE_LOG2 = 12,
    parameter int STAB_STEP_LOG2 = 2,
    parameter int SEL_W          = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              clk_sel_sub,
    input  logic              irq_pend,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic              por_strap,
    input  logic [SEL_W-1:0]  wait_sel,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              pin_hold,
    output logic              pin_hiz,
    output logic              cpu_rst,
    output logic              wake_pulse
);
    import stby_pkg::*;

    stby_state_t state, state_nx;
    logic go_sleep, go_watch, float_sel;
    logic stab_done;
    logic float_q, float_nx;
    logic wake_q, wake_nx;
    logic deep_wake;

    stby_req_decode #(.DATA_W(DATA_W)) dec_i (
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .irq_pend   (irq_pend),
        .clk_sel_sub(clk_sel_sub),
        .go_sleep   (go_sleep),
        .go_watch   (go_watch),
        .float_sel  (float_sel)
    );

    stby_stab_timer #(
        .BASE_LOG2(STAB_BASE_LOG2),
        .STEP_LOG2(STAB_STEP_LOG2),
        .SEL_W    (SEL_W)
    ) tmr_i (
        .clk  (clk),
        .rst_n(por_n),
        .run  (state == ST_STAB),
        .sel  (wait_sel),
        .done (stab_done)
    );

    assign deep_wake = irq_pend && (int'(irq_level) > WAKE_LVL);

    always_comb begin
        state_nx = state;
        float_nx = float_q;
        wake_nx  = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (!ext_rst) begin
                    if (go_sleep) begin
                        state_nx = ST_SLEEP;
                    end else if (go_watch) begin
                        state_nx = ST_WATCH;
                        float_nx = float_sel;
                    end
                end
            end
            ST_SLEEP: begin
                if (ext_rst) begin
                    state_nx = ST_RUN;
                end else if (irq_pend) begin
                    state_nx = ST_RUN;
                    wake_nx  = 1'b1;
                end
            end
            ST_WATCH: begin
                if (ext_rst) begin
                    state_nx = por_strap ? ST_STAB : ST_RUN;
                end else if (deep_wake) begin
                    state_nx = ST_RUN;
                    wake_nx  = 1'b1;
                end
            end
            ST_STAB: begin
                if (stab_done) begin
                    state_nx = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state   <= ST_RUN;
            float_q <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            state   <= state_nx;
            float_q <= float_nx;
            wake_q  <= wake_nx;
        end
    end

    always_comb begin
        cpu_clk_en    = (state == ST_RUN);
        periph_clk_en = (state == ST_RUN) || (state == ST_SLEEP);
        pin_hold      = (state == ST_WATCH) && !float_q;
        pin_hiz       = (state == ST_WATCH) && float_q;
        cpu_rst       = ext_rst || (state == ST_STAB);
        wake_pulse    = wake_q;
    end

    assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!por_n)
        cpu_clk_en && !ext_rst && reg_wr && reg_wdata[SLP_BIT] && !irq_pend
        |=> !cpu_clk_en && periph_clk_en);

    assert_watch_sub_refused_R3: assert property (@(posedge clk) disable iff (!por_n)
        cpu_clk_en && !ext_rst && reg_wr && reg_wdata[WCH_BIT] && !reg_wdata[SLP_BIT] && clk_sel_sub
        |=> cpu_clk_en);

    assert_pending_refused_R4: assert property (@(posedge clk) disable iff (!por_n)
        cpu_clk_en && !ext_rst && reg_wr && irq_pend |=> cpu_clk_en);

    assert_float_from_write_R5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pin_hiz) |-> $past(reg_wr && reg_wdata[FLT_BIT]));

    assert_low_level_stays_R6: assert property (@(posedge clk) disable iff (!por_n)
        (pin_hold || pin_hiz) && !ext_rst && !(irq_pend && int'(irq_level) > WAKE_LVL)
        |=> !periph_clk_en);

    assert_wake_single_R8: assert property (@(posedge clk) disable iff (!por_n)
        wake_pulse |=> !wake_pulse);
endmodule

// File: tb/stby_ctrl_tb_top.sv
module stby_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       clk_sel_sub = 1'b0;
    logic       irq_pend = 1'b0;
    logic [3:0] irq_level = '0;
    logic       por_strap = 1'b0;
    logic [1:0] wait_sel = '0;
    logic cpu_clk_en, periph_clk_en, pin_hold, pin_hiz, cpu_rst, wake_pulse;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;
    int ms = 0;      // 0 run, 1 sleep, 2 watch
    bit mfloat = 1'b0;
    bit mwake = 1'b0;

    localparam int BASE = 4;

    always #5 clk = ~clk;

    stby_ctrl #(.STAB_BASE_LOG2(BASE)) dut_i (
        .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .clk_sel_sub(clk_sel_sub), .irq_pend(irq_pend),
        .irq_level(irq_level), .por_strap(por_strap), .wait_sel(wait_sel),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .pin_hold(pin_hold),
        .pin_hiz(pin_hiz), .cpu_rst(cpu_rst), .wake_pulse(wake_pulse)
    );

    function automatic logic [5:0] exp_outs(int s, bit fl, bit wk);
        case (s)
            0:       return {5'b11000, wk};
            1:       return 6'b010000;
            default: return {2'b00, !fl, fl, 2'b00};
        endcase
    endfunction

    function automatic logic [5:0] outs();
        return {cpu_clk_en, periph_clk_en, pin_hold, pin_hiz, cpu_rst, wake_pulse};
    endfunction

    task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(string tag, bit wr, logic [7:0] d, bit sub, bit irq, logic [3:0] lvl);
        reg_wr = wr; reg_wdata = d; clk_sel_sub = sub; irq_pend = irq; irq_level = lvl;
        mwake = 1'b0;
        case (ms)
            0: if (wr && !irq) begin
                   if (d[6]) ms = 1;
                   else if (d[3] && !sub) begin ms = 2; mfloat = d[5]; end
               end
            1: if (irq) begin ms = 0; mwake = 1'b1; end
            default: if (irq && lvl > 4'd11) begin ms = 0; mwake = 1'b1; end
        endcase
        @(negedge clk);
        reg_wr = 1'b0; irq_pend = 1'b0; clk_sel_sub = 1'b0;
        #1;
        chk(tag, outs(), exp_outs(ms, mfloat, mwake));
    endtask

    task automatic reset_exit(string tag, bit strap, logic [1:0] sel);
        int n;
        por_strap = strap; wait_sel = sel;
        ext_rst = 1'b1;
        #1;
        chk({tag, " rst seen"}, {5'b0, cpu_rst}, 6'd1);
        @(negedge clk);
        ext_rst = 1'b0;
        #1;
        if (strap) begin
            chk({tag, " wait clocks off R9"}, outs(), 6'b000010);
            n = 0;
            while (cpu_rst && n < 5000) begin
                n++;
                @(negedge clk);
                #1;
            end
            chk({tag, " wait length R9"}, 6'(n == (1 << (BASE + 2 * int'(sel)))), 6'd1);
        end
        ms = 0; mwake = 1'b0;
        chk({tag, " back to run no wake R8"}, outs(), exp_outs(0, 1'b0, 1'b0));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        #1;
        chk("R1 reset state", outs(), 6'b110000);

        step("R2 sleep entry", 1, 8'h40, 0, 0, 0);
        step("R7 sleep exit any level", 0, 8'h00, 0, 1, 4'd0);
        step("R8 wake drops", 0, 8'h00, 0, 0, 0);
        step("R11 both bits sleep", 1, 8'h48, 0, 0, 0);
        step("R7 exit again", 0, 8'h00, 0, 1, 4'd3);
        step("R3 subclock refuses watch", 1, 8'h08, 1, 0, 0);
        step("R4 pending refuses watch", 1, 8'h08, 0, 1, 4'd15);
        step("R4 pending refuses sleep", 1, 8'h40, 0, 1, 4'd2);
        step("R3 watch entry hold R5", 1, 8'h08, 0, 0, 0);
        step("R6 level 11 ignored", 0, 8'h00, 0, 1, 4'd11);
        step("R6 level 12 exits", 0, 8'h00, 0, 1, 4'd12);
        step("R5 watch float", 1, 8'h28, 0, 0, 0);
        step("R6 write in watch ignored", 1, 8'h40, 0, 0, 0);
        step("R6 level 15 exits", 0, 8'h00, 0, 1, 4'd15);

        step("R3 watch before reset", 1, 8'h08, 0, 0, 0);
        reset_exit("R10 strap off", 1'b0, 2'd3);
        step("R2 sleep before reset", 1, 8'h40, 0, 0, 0);
        reset_exit("R10 sleep reset", 1'b0, 2'd0);
        step("R3 watch before wait", 1, 8'h28, 0, 0, 0);
        reset_exit("R9 short", 1'b1, 2'd0);
        step("R3 watch before long wait", 1, 8'h08, 0, 0, 0);
        reset_exit("R9 long", 1'b1, 2'd3);

        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] d;
            op = $urandom % 3;
            d = 8'($urandom) & 8'h68;
            if (op == 0)
                step("R4 random write", 1, d, ($urandom % 4) == 0, ($urandom % 4) == 0, 4'($urandom));
            else if (op == 1)
                step("R6 random irq", 0, 8'h00, 0, 1, 4'($urandom));
            else
                step("R8 random idle", 0, 8'h00, 0, 0, 0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule